// File: doc/BRIEF.md
# ADC Result List DMA Engine

This engine fills a buffer of ADC results in external byte-wide SRAM with no help from the processor core. Software first writes a list into the SRAM. Each two-byte slot carries a channel number in the upper nibble of its first byte. Software then loads a 24-bit start pointer, sets the enable bit and powers the ADC up. For each slot the engine reads the channel number and waits for a conversion trigger. It then asks the ADC for one conversion on that channel and writes the 12-bit result back into the same slot.

The list is closed by two slots. The first repeats the last real channel. The second holds the all-ones channel code. The engine leaves both untouched, raises a sticky completion flag and hands the memory bus back to the core. While the engine is enabled and has not finished, core accesses to the SRAM still complete, but they do not reach the memory.

Top module: `adc_list_dma`

## Requirements
- R1: After reset the completion flag, the conversion request and both SRAM strobes are low.
- R2: A pointer byte write (ptr_sel 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16) takes effect only while adc_pwr is low. While adc_pwr is high it is ignored.
- R3: Slots are visited from the pointer upwards in steps of 2, modulo 2^24. The channel of a slot is bits 7:4 of its first byte, and the conversion request carries it on conv_chan.
- R4: A conversion starts only after a trigger from the software, timer or external source. Each conversion uses one trigger. A trigger that arrives while a slot is still being read is kept for that slot. Triggers while the engine is stopped are discarded.
- R5: The first byte of a converted slot becomes {channel, result[11:8]} and is written before the second byte, which becomes result[7:0]. The channel nibble is kept.
- R6: A slot whose channel is 4'hF, or whose following slot has channel 4'hF, ends the list. It gets no conversion and no write, and neither does the slot after it.
- R7: The completion flag is set when the list ends. It stays set until irq_clr is pulsed.
- R8: While dma_en is high and the list has not ended, core writes do not change the memory and core reads return 0.
- R9: Once the list has ended, the core regains the memory even with dma_en still high. No new list starts until dma_en has been low.
- R10: With dma_en low, core reads and writes pass straight to the SRAM, and read data returns one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ptr_wr | input | 1 | Pointer byte write strobe |
| ptr_sel | input | 2 | Pointer byte lane: 0 low, 1 middle, 2 high |
| ptr_byte | input | 8 | Pointer byte value |
| dma_en | input | 1 | Engine enable |
| adc_pwr | input | 1 | ADC powered up |
| irq_clr | input | 1 | Clears the completion flag |
| trig_sw | input | 1 | Software conversion start |
| trig_tmr | input | 1 | Timer overflow conversion start |
| trig_ext | input | 1 | External conversion start |
| conv_req | output | 1 | Conversion request, held until conv_done |
| conv_chan | output | 4 | Channel to convert |
| conv_done | input | 1 | Conversion finished, result valid |
| conv_result | input | 12 | Conversion result |
| core_addr | input | 24 | Core SRAM address |
| core_rd | input | 1 | Core read strobe |
| core_wr | input | 1 | Core write strobe |
| core_wdata | input | 8 | Core write data |
| core_rdata | output | 8 | Core read data, one cycle after core_rd |
| mem_addr | output | 24 | SRAM address |
| mem_rd | output | 1 | SRAM read strobe |
| mem_wr | output | 1 | SRAM byte write strobe |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data, one cycle after mem_rd |
| irq | output | 1 | Completion flag |

## Verification
A slot's channel byte comes back one cycle after its read. The terminator decision needs the next slot's byte, which comes one cycle later. conv_req therefore rises no earlier than four cycles after the engine leaves idle, and only in the cycle after a trigger has been taken. The two result bytes go out on the two cycles after conv_done, and the completion flag is high in the cycle after the terminator is seen.

The bench samples everything on the falling edge. A behavioural model turns each list into queues of expected channels and expected (address, byte) writes. Every edge of conv_req and every engine write strobe is checked against the head of those queues as it happens. Memory contents, the flag and core read data are checked only once the latency above has passed.

// File: rtl/adc_list_dma_pkg.sv
package adc_list_dma_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_CUR,
      ST_RD_NXT,
      ST_CHECK,
      ST_WAIT,
      ST_CONV,
      ST_WR_HI,
      ST_WR_LO,
      ST_END
   } dma_st_t;

endpackage

// File: rtl/adc_list_dma_ptr.sv
module adc_list_dma_ptr #(
   parameter int ADDR_W = 24,
   parameter int LANE_W = 8,
   parameter int STEP   = 2,
   localparam int LANES = ADDR_W / LANE_W,
   localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_wr,
   input  logic [SEL_W-1:0]  ld_sel,
   input  logic [LANE_W-1:0] ld_byte,
   input  logic              ld_allow,
   input  logic              adv,
   output logic [ADDR_W-1:0] ptr
);

   if (ADDR_W % LANE_W != 0) begin : g_bad_lanes
      $error("ADDR_W must be a whole number of lanes");
   end

   logic [ADDR_W-1:0] stepped;
   logic [ADDR_W-1:0] ptr_d;

   assign stepped = adv ? ptr + ADDR_W'(STEP) : ptr;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign ptr_d[g*LANE_W +: LANE_W] =
         (ld_wr && ld_allow && ld_sel == SEL_W'(g)) ? ld_byte
                                                     : stepped[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= ptr_d;
   end

   // R2: with loads locked out and no slot finished, the pointer holds
   a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_allow && !adv) |=> $stable(ptr));

endmodule

// File: rtl/adc_list_dma_trig.sv
module adc_list_dma_trig #(
   parameter int SRC_N = 3,
   parameter bit HOLD  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] src,
   input  logic             arm,
   input  logic             take,
   output logic             pend
);

   if (SRC_N < 1) begin : g_bad_src
      $error("SRC_N must be at least 1");
   end

   if (HOLD) begin : g_hold
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    pend_q <= 1'b0;
         else if (!arm) pend_q <= 1'b0;
         else           pend_q <= (pend_q && !take) || (|src);
      end
      assign pend = pend_q;

      // R4: a disarmed engine discards every trigger
      a_r4_disarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
         !arm |=> !pend);
   end else begin : g_pass
      assign pend = arm && (|src);
   end

endmodule

// File: rtl/adc_list_dma_fsm.sv
module adc_list_dma_fsm
   import adc_list_dma_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 8,
   parameter int ID_W   = 4,
   parameter int RES_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              adc_pwr,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [ID_W-1:0]   rd_id,
   input  logic              pend,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   input  logic              irq_clr,
   output logic              adv,
   output logic              take,
   output logic              arm,
   output logic              conv_req,
   output logic [ID_W-1:0]   conv_chan,
   output logic              eng_rd,
   output logic              eng_wr,
   output logic [ADDR_W-1:0] eng_addr,
   output logic [DATA_W-1:0] eng_wdata,
   output logic              owns,
   output logic              irq
);

   localparam int          HI_W = RES_W - DATA_W;
   localparam logic [ID_W-1:0] TERM = {ID_W{1'b1}};

   if (HI_W + ID_W != DATA_W) begin : g_bad_pack
      $error("channel nibble and upper result bits must fill one byte");
   end

   dma_st_t           st_q, st_d;
   logic [ID_W-1:0]   cur_id_q;
   logic [RES_W-1:0]  res_q;
   logic              irq_q;
   logic              go, busy, term, fin;

   assign go   = en && adc_pwr;
   assign busy = (st_q != ST_IDLE) && (st_q != ST_END);
   assign term = (cur_id_q == TERM) || (rd_id == TERM);
   assign fin  = go && (st_q == ST_CHECK) && term;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (go) st_d = ST_RD_CUR;
         ST_RD_CUR: st_d = ST_RD_NXT;
         ST_RD_NXT: st_d = ST_CHECK;
         ST_CHECK:  st_d = term ? ST_END : ST_WAIT;
         ST_WAIT:   if (pend) st_d = ST_CONV;
         ST_CONV:   if (conv_done) st_d = ST_WR_HI;
         ST_WR_HI:  st_d = ST_WR_LO;
         ST_WR_LO:  st_d = ST_RD_CUR;
         ST_END:    if (!en) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
      if (!go && busy) st_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cur_id_q <= '0;
         res_q    <= '0;
         irq_q    <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_RD_NXT) cur_id_q <= rd_id;
         if (st_q == ST_CONV && conv_done) res_q <= conv_result;
         irq_q <= fin || (irq_q && !irq_clr);
      end
   end

   assign arm       = go && busy;
   assign take      = go && (st_q == ST_WAIT) && pend;
   assign conv_req  = go && (st_q == ST_CONV);
   assign conv_chan = cur_id_q;
   assign eng_rd    = go && ((st_q == ST_RD_CUR) || (st_q == ST_RD_NXT));
   assign eng_wr    = go && ((st_q == ST_WR_HI) || (st_q == ST_WR_LO));
   assign adv       = go && (st_q == ST_WR_LO);
   assign owns      = en && (st_q != ST_END);
   assign irq       = irq_q;

   always_comb begin
      unique case (st_q)
         ST_RD_NXT: eng_addr = ptr + ADDR_W'(2);
         ST_WR_LO:  eng_addr = ptr + ADDR_W'(1);
         default:   eng_addr = ptr;
      endcase
      eng_wdata = (st_q == ST_WR_HI) ? {cur_id_q, res_q[RES_W-1 -: HI_W]}
                                     : res_q[DATA_W-1:0];
   end

   // R4: a request is held with a steady channel until the ADC answers
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> ((conv_req && $stable(conv_chan)) || !(en && adc_pwr)));

   // R6: the terminator code is never sent to the ADC
   a_r6_no_term_req: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> (conv_chan != TERM));

   // R5: the second byte of a result goes to the address after the first
   a_r5_byte_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_wr && $past(eng_wr)) |-> (eng_addr == $past(eng_addr) + ADDR_W'(1)));

   // R3: during a list the pointer moves only by one slot
   a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(arm) && (ptr != $past(ptr))) |-> (ptr == $past(ptr) + ADDR_W'(2)));

   // R7: the flag stays set until cleared
   a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

endmodule

// File: rtl/adc_list_dma.sv
module adc_list_dma
   import adc_list_dma_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 8,
   parameter int ID_W      = 4,
   parameter int RES_W     = 12,
   parameter bit TRIG_HOLD = 1'b1,
   localparam int LANES    = ADDR_W / DATA_W,
   localparam int SEL_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_wr,
   input  logic [SEL_W-1:0]  ptr_sel,
   input  logic [DATA_W-1:0] ptr_byte,
   input  logic              dma_en,
   input  logic              adc_pwr,
   input  logic              irq_clr,
   input  logic              trig_sw,
   input  logic              trig_tmr,
   input  logic              trig_ext,
   output logic              conv_req,
   output logic [ID_W-1:0]   conv_chan,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic              core_rd,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [DATA_W-1:0] core_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              irq
);

   localparam int SRC_N = 3;

   if (ID_W >= DATA_W) begin : g_bad_id
      $error("channel field must be narrower than a byte");
   end

   logic [ADDR_W-1:0] ptr, eng_addr;
   logic [DATA_W-1:0] eng_wdata;
   logic              adv, take, arm, pend, eng_rd, eng_wr, owns, rd_ok_q;

   adc_list_dma_ptr #(.ADDR_W(ADDR_W), .LANE_W(DATA_W), .STEP(2)) ptr_i (
      .clk(clk), .rst_n(rst_n), .ld_wr(ptr_wr), .ld_sel(ptr_sel),
      .ld_byte(ptr_byte), .ld_allow(!adc_pwr), .adv(adv), .ptr(ptr));

   adc_list_dma_trig #(.SRC_N(SRC_N), .HOLD(TRIG_HOLD)) trig_i (
      .clk(clk), .rst_n(rst_n), .src({trig_ext, trig_tmr, trig_sw}),
      .arm(arm), .take(take), .pend(pend));

   adc_list_dma_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .RES_W(RES_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .en(dma_en), .adc_pwr(adc_pwr), .ptr(ptr),
      .rd_id(mem_rdata[DATA_W-1 -: ID_W]), .pend(pend), .conv_done(conv_done),
      .conv_result(conv_result), .irq_clr(irq_clr), .adv(adv), .take(take),
      .arm(arm), .conv_req(conv_req), .conv_chan(conv_chan), .eng_rd(eng_rd),
      .eng_wr(eng_wr), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
      .owns(owns), .irq(irq));

   assign mem_addr  = owns ? eng_addr  : core_addr;
   assign mem_rd    = owns ? eng_rd    : core_rd;
   assign mem_wr    = owns ? eng_wr    : core_wr;
   assign mem_wdata = owns ? eng_wdata : core_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_ok_q <= 1'b0;
      else        rd_ok_q <= core_rd && !owns;
   end

   assign core_rdata = rd_ok_q ? mem_rdata : '0;

   // R8: a core read issued while the engine holds the bus returns zero
   a_r8_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rd && owns) |=> (core_rdata == '0));

endmodule

// File: tb/adc_list_dma_tb_top.sv
module adc_list_dma_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADC_LAT    = 4;
   localparam int WDOG_MAX   = 150000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        ptr_wr = 0; logic [1:0] ptr_sel = 0; logic [7:0] ptr_byte = 0;
   logic        dma_en = 0, adc_pwr = 0, irq_clr = 0;
   logic        trig_sw = 0, trig_tmr = 0, trig_ext = 0;
   logic        conv_req, conv_done = 0;
   logic [3:0]  conv_chan;
   logic [11:0] conv_result = 0;
   logic [23:0] core_addr = 0; logic core_rd = 0, core_wr = 0;
   logic [7:0]  core_wdata = 0, core_rdata;
   logic [23:0] mem_addr; logic mem_rd, mem_wr;
   logic [7:0]  mem_wdata, mem_rdata = 0;
   logic        irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_list_dma dut_i (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_sel(ptr_sel), .ptr_byte(ptr_byte),
      .dma_en(dma_en), .adc_pwr(adc_pwr), .irq_clr(irq_clr), .trig_sw(trig_sw),
      .trig_tmr(trig_tmr), .trig_ext(trig_ext), .conv_req(conv_req), .conv_chan(conv_chan),
      .conv_done(conv_done), .conv_result(conv_result), .core_addr(core_addr),
      .core_rd(core_rd), .core_wr(core_wr), .core_wdata(core_wdata), .core_rdata(core_rdata),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .irq(irq));

   int checks = 0, errors = 0, cyc = 0, adc_cnt = 0;
   bit [7:0]    mem [int];
   logic [3:0]  list_q [$];
   logic [3:0]  chan_q [$];
   logic [31:0] wr_q   [$];
   logic        req_prev = 1'b0;

   function automatic logic [11:0] adc_val(input logic [3:0] ch);
      return {ch ^ 4'h9, ch, ~ch};
   endfunction

   function automatic int rd_mem(input int a);
      return mem.exists(a) ? int'(mem[a]) : 0;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // synchronous SRAM, one cycle read latency
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
      if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
   end

   // ADC model: answers a held request after ADC_LAT cycles
   always @(negedge clk) begin
      if (conv_done) begin
         conv_done = 1'b0;
         adc_cnt   = 0;
      end else if (conv_req) begin
         if (adc_cnt == ADC_LAT) begin
            conv_done   = 1'b1;
            conv_result = adc_val(conv_chan);
         end else adc_cnt++;
      end else adc_cnt = 0;
   end

   // per-clock comparison against the reference queues
   always @(negedge clk) begin
      if (rst_n) begin
         if (conv_req && !req_prev) begin
            if (chan_q.size() == 0) chk(1'b0, "R6 unexpected conversion", conv_chan, 0);
            else begin
               logic [3:0] e;
               e = chan_q.pop_front();
               chk(conv_chan == e, "R3 channel order", conv_chan, e);
            end
         end
         if (mem_wr && !core_wr) begin
            if (wr_q.size() == 0) chk(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 0);
            else begin
               logic [31:0] w;
               w = wr_q.pop_front();
               chk({mem_addr, mem_wdata} == w[31:0], "R5 write addr/data",
                   {mem_addr, mem_wdata}, w);
            end
         end
         req_prev = conv_req;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WDOG_MAX) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic load_ptr(input logic [23:0] a);
      ptr_wr = 1; ptr_sel = 0; ptr_byte = a[7:0];   tick(1);
      ptr_sel = 1;             ptr_byte = a[15:8];  tick(1);
      ptr_sel = 2;             ptr_byte = a[23:16]; tick(1);
      ptr_wr = 0;
   endtask

   task automatic pulse(input int src);
      if (src == 0) trig_sw = 1; else if (src == 1) trig_tmr = 1; else trig_ext = 1;
      tick(1);
      trig_sw = 0; trig_tmr = 0; trig_ext = 0;
   endtask

   // reference model: writes the list, builds the expected queues
   task automatic prep(input logic [23:0] base, output int n);
      n = 0;
      for (int i = 0; i < list_q.size(); i++) begin
         logic [23:0] a;
         a = base + 24'(2*i);
         mem[int'(a)] = {list_q[i], 4'hA};
         mem[int'(a + 24'd1)] = 8'h77;
      end
      for (int i = 0; i < list_q.size(); i++) begin
         logic [3:0] id, nx;
         logic [23:0] a;
         logic [11:0] r;
         id = list_q[i];
         nx = (i + 1 < list_q.size()) ? list_q[i+1] : 4'hF;
         if (id == 4'hF || nx == 4'hF) break;
         a = base + 24'(2*i);
         r = adc_val(id);
         chan_q.push_back(id);
         wr_q.push_back({a, id, r[11:8]});
         wr_q.push_back({a + 24'd1, r[7:0]});
         n++;
      end
   endtask

   task automatic run(input int n, input int src, input bit early, input int hold);
      dma_en = 1; tick(1);
      adc_pwr = 1;
      if (early) begin tick(1); pulse(src); end
      if (hold > 0) begin
         tick(hold);
         chk(!conv_req, "R4 no conversion without trigger", conv_req, 0);
         core_wr = 1; core_addr = 24'h000100; core_wdata = 8'h5A; tick(1);
         core_wr = 0; core_rd = 1; core_addr = 24'h012340; tick(1);
         chk(core_rdata == 8'h00, "R8 blocked core read", core_rdata, 0);
         core_rd = 0;
      end
      for (int k = 0; k < n; k++) begin
         if (!(early && k == 0)) begin tick(3); pulse(src); end
         while (!conv_req) tick(1);
         while (conv_req) tick(1);
      end
      for (int w = 0; w < 30 && !irq; w++) tick(1);
   endtask

   task automatic stop_all();
      dma_en = 0; tick(1); adc_pwr = 0; tick(2);
   endtask

   task automatic clear_irq();
      irq_clr = 1; tick(1); irq_clr = 0;
   endtask

   initial begin
      int n;
      tick(3);
      rst_n = 1;
      tick(1);
      chk(irq == 0,     "R1 irq after reset", irq, 0);
      chk(conv_req == 0, "R1 conv_req after reset", conv_req, 0);
      chk(mem_wr == 0,  "R1 mem_wr after reset", mem_wr, 0);
      chk(mem_rd == 0,  "R1 mem_rd after reset", mem_rd, 0);

      // list 2,5,8,3 then duplicate 3 and terminator; software trigger
      list_q = '{4'h2, 4'h5, 4'h8, 4'h3, 4'h3, 4'hF};
      prep(24'h012340, n);
      load_ptr(24'h012340);
      adc_pwr = 1; tick(1);
      ptr_wr = 1; ptr_sel = 0; ptr_byte = 8'hEE; tick(1); ptr_wr = 0;  // R2 ignored
      adc_pwr = 0; tick(1);
      run(n, 0, 1'b0, 20);
      chk(irq == 1, "R7 flag on list end", irq, 1);
      chk(chan_q.size() == 0, "R3 all channels converted", chan_q.size(), 0);
      chk(wr_q.size() == 0, "R5 all result bytes written", wr_q.size(), 0);
      chk(!mem.exists(32'h0123EE), "R2 load while powered ignored", rd_mem(32'h0123EE), 0);
      chk(rd_mem(32'h012340) == {4'h2, adc_val(4'h2)[11:8]}, "R5 id nibble kept",
          rd_mem(32'h012340), {4'h2, adc_val(4'h2)[11:8]});
      chk(rd_mem(32'h012348) == 8'h3A, "R6 duplicate slot untouched", rd_mem(32'h012348), 8'h3A);
      chk(rd_mem(32'h012349) == 8'h77, "R6 duplicate slot low byte", rd_mem(32'h012349), 8'h77);
      chk(rd_mem(32'h01234A) == 8'hFA, "R6 terminator slot untouched", rd_mem(32'h01234A), 8'hFA);
      chk(rd_mem(32'h000100) == 0, "R8 blocked core write", rd_mem(32'h000100), 0);
      tick(10);
      chk(irq == 1, "R7 flag sticky", irq, 1);
      clear_irq();
      chk(irq == 0, "R7 flag cleared", irq, 0);

      // R9: bus returned while dma_en still high, no restart
      core_wr = 1; core_addr = 24'h000101; core_wdata = 8'h3C; tick(1); core_wr = 0;
      chk(rd_mem(32'h000101) == 8'h3C, "R9 core write after end", rd_mem(32'h000101), 8'h3C);
      pulse(0); tick(10);
      chk(!conv_req && !irq, "R9 no restart while enabled", {conv_req, irq}, 0);
      stop_all();

      // R10: plain core read with engine disabled
      core_rd = 1; core_addr = 24'h012341; tick(1);
      chk(core_rdata == adc_val(4'h2)[7:0], "R10 core read passthrough",
          core_rdata, adc_val(4'h2)[7:0]);
      core_rd = 0;

      // R3 wrap at the top of the space, timer trigger
      list_q = '{4'h1, 4'h1, 4'hF};
      prep(24'hFFFFFC, n);
      load_ptr(24'hFFFFFC);
      run(n, 1, 1'b0, 0);
      chk(irq == 1 && wr_q.size() == 0, "R3 wrap list finished", wr_q.size(), 0);
      chk(rd_mem(32'h000000) == 8'hF0 || rd_mem(32'h000000) == 8'hFA, "R6 wrapped terminator kept",
          rd_mem(32'h000000), 8'hFA);
      clear_irq(); stop_all();

      // terminator only, external trigger
      list_q = '{4'hF};
      prep(24'h002000, n);
      load_ptr(24'h002000);
      run(n, 2, 1'b0, 0);
      chk(irq == 1, "R7 flag on empty list", irq, 1);
      chk(rd_mem(32'h002000) == 8'hFA, "R6 empty list untouched", rd_mem(32'h002000), 8'hFA);
      clear_irq(); stop_all();

      // R4 trigger arriving during the slot read is kept
      list_q = '{4'h9, 4'h9, 4'hF};
      prep(24'h003000, n);
      load_ptr(24'h003000);
      run(n, 2, 1'b1, 0);
      chk(irq == 1 && chan_q.size() == 0, "R4 early trigger kept", chan_q.size(), 0);
      clear_irq(); stop_all();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule